// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block holds the static configuration for a memory bus controller: seven 16-bit registers that set wait states, data bus width, the timing of the different memory interfaces and refresh. A simple synchronous slave port reaches the registers. The port carries an address, a size flag that selects a 16-bit or 32-bit access, a write enable and 32-bit write and read data. All register contents also leave the block as one flat vector, so the controller logic that consumes them can use them directly.

Writes are guarded by a key so that a stray store cannot change the controller's setup. A write lands only when it is a 32-bit access to a valid register offset and its upper half carries the key 16'hA55A. Every other write attempt is dropped. A dropped attempt raises a one-cycle rejection pulse one cycle later. Reads work at either size and always return zero in the upper half.

Top module: `keyed_cfg_bank`

## Requirements
- R1: The seven registers sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. Register n is selected by address bits [4:2] equal to n when address bits [1:0] are zero.
- R2: `rdData` is combinational on `addr` and ignores `size32`. Bits [15:0] hold the addressed register and bits [31:16] are always zero.
- R3: A keyed write stores `wrData[15:0]`, masked by that register's writable bits, on the clock edge of the access. A keyed write has `wrEn`=1, `size32`=1, `wrData[31:16]`=16'hA55A and a valid offset. A read in the following cycle returns the new value.
- R4: A 32-bit write whose upper half is not 16'hA55A leaves every register unchanged.
- R5: A write with `size32`=0 leaves every register unchanged, whatever its data.
- R6: An offset that is not listed in R1 reads as zero and is never written, even with the key. This covers 0x1C and every offset whose bits [1:0] are not zero.
- R7: The bits outside each register's writable mask always read zero. The masks for registers 0 to 6 are 0x0FFF, 0xFFFF, 0x00FF, 0x7FFF, 0xFFF8, 0x00FF and 0x0FFF.
- R8: While `rstN` is low at a clock edge, every register is loaded with its reset value. Register 1 resets to 0x03F0, register 2 resets to 0x00FC and all the others reset to zero. `wrRejected` is cleared at the same time.
- R9: `wrRejected` is high for exactly the one cycle that follows a write attempt that is not keyed (R4, R5, R6). It is low after an accepted write and after a cycle with no write.
- R10: `cfgRegs[16n+15:16n]` always equals register n. It changes only on an accepted write or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | 5 | Byte offset of the access |
| size32 | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| wrEn | input | 1 | Write request for this cycle |
| wrData | input | 32 | Write data; upper half carries the key |
| rdData | output | 32 | Read data for `addr` |
| wrRejected | output | 1 | Pulses one cycle after a dropped write |
| cfgRegs | output | 112 | All seven registers, register 0 in the low bits |

## Verification
Two functions can fall in the same cycle. The rejection pulse from a dropped attempt is high during the next access, which may itself be an accepted write or a read of the register that the dropped attempt aimed at. The bench provokes this with back-to-back traffic: directed pairs in which a rejected attempt is followed at once by a keyed write, plus a long stretch of randomly mixed keyed, unkeyed, narrow and out-of-range accesses. In every cycle a behavioural model judges three things together: the read data, the flat register vector and the pulse. A pulse that leaks into the wrong cycle, or a rejected value that appears on the following read, therefore shows up as a mismatch in that same cycle.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int NUM_REGS = 7;
  localparam int REG_W    = 16;
  localparam int BUS_W    = 32;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int ADDR_W   = IDX_W + 2;
  localparam int KEY_W    = BUS_W - REG_W;
  localparam logic [KEY_W-1:0] WR_KEY = 16'hA55A;

  // Strobes from control to datapath
  typedef struct packed {
    logic             hit;    // address selects an implemented register
    logic [IDX_W-1:0] idx;    // register index
    logic             load;   // accepted keyed write
    logic             reject; // dropped write attempt
  } bankStrobe_t;

  function automatic logic [REG_W-1:0] fieldMask(input int i);
    case (i)
      0: return 16'h0FFF;
      1: return 16'hFFFF;
      2: return 16'h00FF;
      3: return 16'h7FFF;
      4: return 16'hFFF8;
      5: return 16'h00FF;
      6: return 16'h0FFF;
      default: return '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] resetValue(input int i);
    case (i)
      1: return 16'h03F0;
      2: return 16'h00FC;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfgbank_ctrl.sv
module cfgbank_ctrl
  import cfgbank_pkg::*;
#(
  parameter int NR = NUM_REGS,
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    addr,
  input  logic             size32,
  input  logic             wrEn,
  input  logic [KEY_W-1:0] keyField,
  output bankStrobe_t      strobe,
  output logic             wrRejected
);
  logic aligned;
  logic inRange;
  logic keyOk;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    inRange = ({1'b0, addr[AW-1:2]} < (IW+1)'(NR));
    keyOk   = size32 && (keyField == WR_KEY);
    strobe.hit    = aligned && inRange;
    strobe.idx    = addr[AW-1:2];
    strobe.load   = wrEn && strobe.hit && keyOk;
    strobe.reject = wrEn && !(strobe.hit && keyOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrRejected <= 1'b0;
    else       wrRejected <= strobe.reject;
  end
endmodule

// File: rtl/cfgbank_datapath.sv
module cfgbank_datapath
  import cfgbank_pkg::*;
#(
  parameter int NR = NUM_REGS,
  parameter int RW = REG_W,
  parameter int BW = BUS_W,
  parameter int IW = IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  bankStrobe_t      strobe,
  input  logic [RW-1:0]    wrLow,
  output logic [BW-1:0]    rdData,
  output logic [NR*RW-1:0] cfgRegs
);
  logic [RW-1:0] regQ [NR];

  for (genvar g = 0; g < NR; g++) begin : gReg
    localparam logic [RW-1:0] MASK = fieldMask(g);
    localparam logic [RW-1:0] RSTV = resetValue(g);
    always_ff @(posedge clk) begin
      if (!rstN)
        regQ[g] <= RSTV;
      else if (strobe.load && strobe.idx == IW'(g))
        regQ[g] <= wrLow & MASK;
    end
    assign cfgRegs[g*RW +: RW] = regQ[g];
  end

  logic [RW-1:0] rdSel;
  always_comb begin
    rdSel = '0;
    for (int i = 0; i < NR; i++)
      if (strobe.hit && strobe.idx == IW'(i)) rdSel = regQ[i];
    rdData = {{(BW-RW){1'b0}}, rdSel};
  end
endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
  import cfgbank_pkg::*;
#(
  parameter int NR = NUM_REGS,
  parameter int RW = REG_W,
  parameter int BW = BUS_W,
  parameter int AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    addr,
  input  logic             size32,
  input  logic             wrEn,
  input  logic [BW-1:0]    wrData,
  output logic [BW-1:0]    rdData,
  output logic             wrRejected,
  output logic [NR*RW-1:0] cfgRegs
);
  bankStrobe_t strobe;

  cfgbank_ctrl #(.NR(NR), .AW(AW), .IW(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .size32(size32), .wrEn(wrEn),
    .keyField(wrData[BW-1:RW]), .strobe(strobe), .wrRejected(wrRejected)
  );

  cfgbank_datapath #(.NR(NR), .RW(RW), .BW(BW), .IW(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrLow(wrData[RW-1:0]),
    .rdData(rdData), .cfgRegs(cfgRegs)
  );
endmodule

// File: rtl/cfgbank_checks.sv
module cfgbank_checks
  import cfgbank_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic [ADDR_W-1:0]         addr,
  input logic                      size32,
  input logic                      wrEn,
  input logic [BUS_W-1:0]          wrData,
  input logic [BUS_W-1:0]          rdData,
  input logic                      wrRejected,
  input logic [NUM_REGS*REG_W-1:0] cfgRegs
);
  logic [NUM_REGS*REG_W-1:0] maskFlat;
  logic [NUM_REGS*REG_W-1:0] resetFlat;
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      maskFlat[i*REG_W +: REG_W]  = fieldMask(i);
      resetFlat[i*REG_W +: REG_W] = resetValue(i);
    end
  end

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[BUS_W-1:REG_W] == '0);

  assert_wrong_key_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && size32 && wrData[BUS_W-1:REG_W] != WR_KEY) |=> $stable(cfgRegs));

  assert_narrow_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !size32) |=> $stable(cfgRegs));

  assert_unaligned_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (addr[1:0] != 2'b00) |-> (rdData == '0));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRegs & ~maskFlat) == '0);

  assert_reset_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (cfgRegs == resetFlat && !wrRejected));

  assert_narrow_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !size32) |=> wrRejected);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !wrRejected);

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(cfgRegs));
endmodule

bind keyed_cfg_bank cfgbank_checks uChecks (
  .clk(clk), .rstN(rstN), .addr(addr), .size32(size32), .wrEn(wrEn),
  .wrData(wrData), .rdData(rdData), .wrRejected(wrRejected), .cfgRegs(cfgRegs)
);

// File: tb/keyed_cfg_bank_test.sv
`timescale 1ns/1ps
module keyed_cfg_bank_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [4:0]   addr = '0;
  logic         size32 = 1'b0;
  logic         wrEn = 1'b0;
  logic [31:0]  wrData = '0;
  logic [31:0]  rdData;
  logic         wrRejected;
  logic [111:0] cfgRegs;

  always #2 clk = ~clk; // 250 MHz

  keyed_cfg_bank uut (
    .clk(clk), .rstN(rstN), .addr(addr), .size32(size32), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .wrRejected(wrRejected), .cfgRegs(cfgRegs)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [15:0] model [7];
  logic        rejExp;
  logic [15:0] maskOf [7] = '{16'h0FFF, 16'hFFFF, 16'h00FF, 16'h7FFF, 16'hFFF8, 16'h00FF, 16'h0FFF};
  logic [15:0] rstOf  [7] = '{16'h0000, 16'h03F0, 16'h00FC, 16'h0000, 16'h0000, 16'h0000, 16'h0000};

  function automatic bit validOff(input logic [4:0] a);
    return (a[1:0] == 2'b00) && (a[4:2] < 3'd7);
  endfunction

  function automatic logic [31:0] expRead(input logic [4:0] a);
    if (validOff(a)) return {16'h0000, model[a[4:2]]};
    return 32'h0;
  endfunction

  function automatic logic [111:0] expFlat();
    logic [111:0] f;
    for (int i = 0; i < 7; i++) f[i*16 +: 16] = model[i];
    return f;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access: drive at negedge, check before the next posedge, update the model at the edge
  task automatic access(input logic [4:0] a, input logic s, input logic w,
                        input logic [31:0] d, input string tag);
    @(negedge clk);
    addr = a; size32 = s; wrEn = w; wrData = d;
    #1;
    check({tag, " read"}, 128'(rdData), 128'(expRead(a)));
    check({tag, " flat R10"}, 128'(cfgRegs), 128'(expFlat()));
    check({tag, " pulse R9"}, 128'(wrRejected), 128'(rejExp));
    if (w) begin
      if (s && d[31:16] == 16'hA55A && validOff(a)) begin
        model[a[4:2]] = d[15:0] & maskOf[a[4:2]];
        rejExp = 1'b0;
      end else begin
        rejExp = 1'b1;
      end
    end else begin
      rejExp = 1'b0;
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 7; i++) model[i] = rstOf[i];
    rejExp = 1'b0;
    // R8: hold reset for several cycles, with a keyed write pending on the port
    addr = 5'h04; size32 = 1'b1; wrEn = 1'b1; wrData = 32'hA55A_FFFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    rstN = 1'b1;
    #1;
    check("R8 reset flat", 128'(cfgRegs), 128'(expFlat()));
    check("R8 reset pulse", 128'(wrRejected), 128'(0));

    // R1 R2 R8: read every offset at both sizes
    for (int i = 0; i < 8; i++) access(5'(i*4), 1'b1, 1'b0, 32'h0, "R1 R8 read32");
    for (int i = 0; i < 8; i++) access(5'(i*4), 1'b0, 1'b0, 32'h0, "R2 read16");

    // R3 R7: keyed writes to every register with all ones, then read back
    for (int i = 0; i < 7; i++) access(5'(i*4), 1'b1, 1'b1, 32'hA55A_FFFF, "R3 R7 keyed");
    for (int i = 0; i < 7; i++) access(5'(i*4), 1'b1, 1'b0, 32'h0, "R3 R7 readback");

    // R4: wrong key, near misses of the key
    access(5'h08, 1'b1, 1'b1, 32'hA55B_0011, "R4 wrongkey");
    access(5'h08, 1'b1, 1'b1, 32'h5AA5_0011, "R4 swapped key");
    access(5'h08, 1'b1, 1'b1, 32'h0000_0011, "R4 zero key");
    // R5: narrow write with the key in the upper half
    access(5'h0C, 1'b0, 1'b1, 32'hA55A_1234, "R5 narrow keyed");
    // a rejected attempt followed at once by an accepted write
    access(5'h0C, 1'b1, 1'b1, 32'hA55A_1234, "R3 after reject");
    access(5'h0C, 1'b1, 1'b0, 32'h0, "R3 R9 readback");
    // R6: keyed writes to invalid offsets
    access(5'h1C, 1'b1, 1'b1, 32'hA55A_BEEF, "R6 off 0x1C");
    access(5'h05, 1'b1, 1'b1, 32'hA55A_BEEF, "R6 unaligned");
    access(5'h1E, 1'b0, 1'b0, 32'h0, "R6 read unaligned");
    access(5'h04, 1'b1, 1'b0, 32'h0, "R6 R10 neighbour");
    access(5'h04, 1'b1, 1'b0, 32'h0, "R9 quiet");

    // R7: reserved bits of register 4 (mask 0xFFF8)
    access(5'h10, 1'b1, 1'b1, 32'hA55A_0007, "R7 reserved only");
    access(5'h10, 1'b1, 1'b0, 32'h0, "R7 read");

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [4:0]  ra;
      logic        rs;
      logic        rw;
      logic [31:0] rd;
      int          k;
      k  = int'($urandom_range(0, 9));
      ra = (k < 8) ? 5'($urandom_range(0, 6) * 4) : 5'($urandom_range(0, 31));
      rs = ($urandom_range(0, 4) != 0);
      rw = ($urandom_range(0, 2) != 0);
      rd[15:0]  = 16'($urandom());
      rd[31:16] = ($urandom_range(0, 3) != 0) ? 16'hA55A : 16'($urandom());
      access(ra, rs, rw, rd, "R3 R4 R5 R6 R9 random");
    end

    // R8: reset again after traffic
    @(negedge clk);
    wrEn = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 7; i++) model[i] = rstOf[i];
    rejExp = 1'b0;
    #1;
    check("R8 second reset", 128'(cfgRegs), 128'(expFlat()));
    access(5'h08, 1'b1, 1'b0, 32'h0, "R8 read after reset");

    @(negedge clk);
    finish_up();
  end
endmodule